// File: doc/BRIEF.md
# Variable-Length SPI Master Transfer Engine

This block runs one full-duplex SPI transfer each time it is started. The word length is any value from 8 to 32 bits, and the bit order is selectable. The edge that launches transmit data and the edge that samples receive data are chosen separately, as rising or falling edges of SCLK. Together with a selectable SCLK idle level, this covers every clock/phase pairing and also the uncommon mixed ones. SCLK comes from the system clock through a programmable even divider. For 32-bit words, an optional suspend mode holds SCLK idle for a programmable number of SCLK periods after each of the first three bytes, while the slave select stays low.

The block takes all of its configuration from its inputs on the cycle it accepts a start strobe. The receive word is updated once per transfer, in the cycle that carries the done pulse.

Top module: `vsm_spi_master`

## Requirements
- R1: After reset, ss_n is 1, busy is 0, done is 0 and rx_word is 0. From the first clock after reset on, sclk equals sclk_idle while no transfer runs.
- R2: A transfer has N = len_m1+1 SCLK periods. A len_m1 below 7 gives N = 8.
- R3: With lsb_first=0 the word goes out starting at tx_word[N-1] and the first received bit lands in rx_word[N-1]. With lsb_first=1 the word goes out starting at tx_word[0] and the first received bit lands in rx_word[0].
- R4: MOSI changes only on the launch edge (falling when tx_on_fall=1, rising otherwise). Bit k is stable at the other edge of SCLK period k. Bit 0 is driven from the cycle in which ss_n falls.
- R5: MISO is sampled on the chosen edge (falling when rx_on_fall=1, rising otherwise), one bit per period. rx_word is right-aligned, with bits above N-1 equal to 0.
- R6: Every SCLK half period lasts half_div+1 system clocks. The first edge away from the idle level comes half_div+1 clocks after ss_n falls, and sclk changes only at these boundaries.
- R7: With suspend_en=1 and N=32, the idle time after periods 7, 15 and 23 is stretched by 2*(gap_len+1) half periods. During this time ss_n stays 0 and sclk stays at the idle level. For N<32, suspend_en has no effect.
- R8: done is a one-clock pulse, one clock after the final edge that returns sclk to idle. In that cycle ss_n is 1, busy is 0 and rx_word holds the received word.
- R9: A start strobe while busy is ignored. Configuration and tx_word changes during a transfer do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| tx_word | input | 32 | Word to transmit |
| len_m1 | input | 5 | Word length minus one |
| lsb_first | input | 1 | 1: least significant bit first |
| tx_on_fall | input | 1 | 1: launch MOSI on falling SCLK edge |
| rx_on_fall | input | 1 | 1: sample MISO on falling SCLK edge |
| sclk_idle | input | 1 | SCLK level between transfers |
| suspend_en | input | 1 | Enable byte gaps in 32-bit words |
| gap_len | input | GAP_W | Gap length minus one, in SCLK periods |
| half_div | input | HALF_W | SCLK half period minus one, in clocks |
| miso | input | 1 | Serial data from slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| rx_word | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| ss_n | output | 1 | Active-low slave select |

## Verification
Several properties are checked on every cycle by the embedded assertions:
- the done pulse lasts one clock and coincides with a released select;
- the select stays low with SCLK idle throughout a suspend gap;
- SCLK holds still between divider ticks;
- the bit counter never passes the latched length;
- a start strobe during a transfer neither ends the transfer nor alters the latched length;
- SCLK follows the idle input between transfers.

Bit order, the pairing of launch and sample edges, right alignment of the received word and the exact gap durations are data- and timing-dependent. Only the bench's slave model shows these, by timing every SCLK edge and comparing the captured MOSI bits and rx_word against values computed from the requirements.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
    localparam int WORD_W  = 32;
    localparam int LEN_W   = $clog2(WORD_W);
    localparam int MIN_LEN = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_GAP    = 2'd2,
        ST_FINISH = 2'd3
    } vsm_state_e;
endpackage

// File: rtl/vsm_tick.sv
module vsm_tick #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [HALF_W-1:0] limit,
    output logic              tick
);
    logic [HALF_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == limit);

    always_comb begin
        if (clear || tick) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: the half-period counter never runs past its limit
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> cnt_q <= limit);
endmodule

// File: rtl/vsm_order.sv
module vsm_order
    import vsm_pkg::*;
(
    input  logic [WORD_W-1:0] tx_in,
    input  logic [LEN_W-1:0]  tx_len_m1,
    input  logic              tx_lsb,
    output logic [WORD_W-1:0] tx_out,
    output logic              tx_first,
    input  logic [WORD_W-1:0] rx_in,
    input  logic [LEN_W-1:0]  rx_len_m1,
    input  logic              rx_lsb,
    output logic [WORD_W-1:0] rx_out
);
    localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(WORD_W - 1);

    logic [LEN_W-1:0] tx_pad, rx_pad;

    assign tx_pad = TOP_IDX - tx_len_m1;
    assign rx_pad = TOP_IDX - rx_len_m1;

    // MSB-first words are left-justified so the shifter always emits bit WORD_W-1
    assign tx_out   = tx_lsb ? tx_in : (tx_in << tx_pad);
    assign tx_first = tx_lsb ? tx_in[0] : tx_out[WORD_W-1];

    // LSB-first capture fills from the top; bring it down to bit 0
    assign rx_out   = rx_lsb ? (rx_in >> rx_pad) : rx_in;
endmodule

// File: rtl/vsm_spi_master.sv
module vsm_spi_master
    import vsm_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              lsb_first,
    input  logic              tx_on_fall,
    input  logic              rx_on_fall,
    input  logic              sclk_idle,
    input  logic              suspend_en,
    input  logic [GAP_W-1:0]  gap_len,
    input  logic [HALF_W-1:0] half_div,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n
);
    localparam logic [LEN_W-1:0] SHORT_M1 = LEN_W'(MIN_LEN - 1);
    localparam logic [LEN_W-1:0] FULL_M1  = LEN_W'(WORD_W - 1);

    typedef struct packed {
        vsm_state_e        st;
        logic              phase;
        logic [LEN_W-1:0]  bitn;
        logic [LEN_W-1:0]  lenm1;
        logic              lsb;
        logic              tx_lead;
        logic              rx_lead;
        logic              idle;
        logic              susp;
        logic [GAP_W:0]    gcnt;
        logic [GAP_W-1:0]  gap;
        logic [HALF_W-1:0] half;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
        logic [WORD_W-1:0] rx_word;
        logic              sclk;
        logic              mosi;
        logic              ss_n;
        logic              done;
    } vsm_regs_t;

    vsm_regs_t r_d, r_q;

    logic              tick;
    logic [LEN_W-1:0]  len_eff;
    logic [WORD_W-1:0] tx_aligned, rx_aligned, tx_next;
    logic              tx_first;

    assign len_eff = (len_m1 < SHORT_M1) ? SHORT_M1 : len_m1;

    vsm_tick #(.HALF_W(HALF_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (r_q.st == ST_IDLE),
        .limit (r_q.half),
        .tick  (tick)
    );

    vsm_order u_order (
        .tx_in     (tx_word),
        .tx_len_m1 (len_eff),
        .tx_lsb    (lsb_first),
        .tx_out    (tx_aligned),
        .tx_first  (tx_first),
        .rx_in     (r_q.rx_sh),
        .rx_len_m1 (r_q.lenm1),
        .rx_lsb    (r_q.lsb),
        .rx_out    (rx_aligned)
    );

    assign tx_next = r_q.lsb ? (r_q.tx_sh >> 1) : (r_q.tx_sh << 1);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sclk = sclk_idle;
                r_d.ss_n = 1'b1;
                if (start) begin
                    r_d.st      = ST_RUN;
                    r_d.phase   = 1'b0;
                    r_d.bitn    = '0;
                    r_d.lenm1   = len_eff;
                    r_d.lsb     = lsb_first;
                    // the leading edge is rising exactly when idle is low
                    r_d.tx_lead = (tx_on_fall == sclk_idle);
                    r_d.rx_lead = (rx_on_fall == sclk_idle);
                    r_d.idle    = sclk_idle;
                    r_d.susp    = suspend_en && (len_eff == FULL_M1);
                    r_d.gap     = gap_len;
                    r_d.half    = half_div;
                    r_d.tx_sh   = tx_aligned;
                    r_d.rx_sh   = '0;
                    r_d.mosi    = tx_first;
                    r_d.ss_n    = 1'b0;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (!r_q.phase) begin
                        r_d.phase = 1'b1;
                        r_d.sclk  = ~r_q.idle;
                        if (r_q.tx_lead && r_q.bitn != '0) begin
                            r_d.tx_sh = tx_next;
                            r_d.mosi  = r_q.lsb ? tx_next[0] : tx_next[WORD_W-1];
                        end
                        if (r_q.rx_lead)
                            r_d.rx_sh = r_q.lsb ? {miso, r_q.rx_sh[WORD_W-1:1]}
                                                : {r_q.rx_sh[WORD_W-2:0], miso};
                    end else begin
                        r_d.phase = 1'b0;
                        r_d.sclk  = r_q.idle;
                        if (!r_q.tx_lead && r_q.bitn != r_q.lenm1) begin
                            r_d.tx_sh = tx_next;
                            r_d.mosi  = r_q.lsb ? tx_next[0] : tx_next[WORD_W-1];
                        end
                        if (!r_q.rx_lead)
                            r_d.rx_sh = r_q.lsb ? {miso, r_q.rx_sh[WORD_W-1:1]}
                                                : {r_q.rx_sh[WORD_W-2:0], miso};
                        if (r_q.bitn == r_q.lenm1) begin
                            r_d.st = ST_FINISH;
                        end else begin
                            r_d.bitn = r_q.bitn + 1'b1;
                            if (r_q.susp && r_q.bitn[2:0] == 3'd7) begin
                                r_d.st   = ST_GAP;
                                r_d.gcnt = {r_q.gap, 1'b1};
                            end
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.gcnt == '0) r_d.st   = ST_RUN;
                    else                r_d.gcnt = r_q.gcnt - 1'b1;
                end
            end
            ST_FINISH: begin
                r_d.st      = ST_IDLE;
                r_d.done    = 1'b1;
                r_d.ss_n    = 1'b1;
                r_d.rx_word = rx_aligned;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.ss_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign rx_word = r_q.rx_word;
    assign sclk    = r_q.sclk;
    assign mosi    = r_q.mosi;
    assign ss_n    = r_q.ss_n;

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && ss_n));

    assert_gap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_GAP) |-> (!ss_n && sclk == r_q.idle));

    assert_sclk_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && !tick) |=> $stable(sclk));

    assert_bit_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.bitn <= r_q.lenm1));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && r_q.st != ST_FINISH) |=> (busy && $stable(r_q.lenm1)));

    assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && $past(r_q.st == ST_IDLE) && $past(rst_n))
            |-> sclk == $past(sclk_idle));
endmodule

// File: tb/vsm_spi_master_bench.sv
`timescale 1ns/1ps
module vsm_spi_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tx_word = '0;
    logic [4:0]  len_m1 = 5'd7;
    logic        lsb_first = 1'b0, tx_on_fall = 1'b0, rx_on_fall = 1'b0;
    logic        sclk_idle = 1'b1, suspend_en = 1'b0, miso = 1'b0;
    logic [3:0]  gap_len = '0;
    logic [7:0]  half_div = '0;
    logic        busy, done, sclk, mosi, ss_n;
    logic [31:0] rx_word;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vsm_spi_master u_vsm_spi_master (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .len_m1(len_m1),
        .lsb_first(lsb_first), .tx_on_fall(tx_on_fall), .rx_on_fall(rx_on_fall),
        .sclk_idle(sclk_idle), .suspend_en(suspend_en), .gap_len(gap_len),
        .half_div(half_div), .miso(miso), .busy(busy), .done(done), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .ss_n(ss_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int eff_len(input logic [4:0] lm1);
        return (lm1 < 5'd7) ? 8 : int'(lm1) + 1;
    endfunction

    function automatic logic [31:0] len_mask(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    endfunction

    // bit k of the result = k-th bit on the wire
    function automatic logic [31:0] wire_order(input logic [31:0] w, input int n, input bit lsb);
        logic [31:0] r = '0;
        for (int k = 0; k < n; k++) r[k] = lsb ? w[k] : w[n-1-k];
        return r;
    endfunction

    task automatic run_xfer(input logic [4:0] lm1, input bit lsb, input bit txf, input bit rxf,
                            input bit idl, input bit susp, input logic [3:0] g,
                            input logic [7:0] hd, input logic [31:0] tw, input logic [31:0] sw,
                            input bit poke);
        int n = eff_len(lm1);
        int h = int'(hd) + 1;
        logic [31:0] slave_seq = wire_order(sw, n, lsb);
        logic [31:0] exp_tx = wire_order(tw, n, lsb);
        logic [31:0] cap = '0;
        int t = 0, last_t = 0, k = 0, sidx = 0, err_t = 0, err_g = 0, done_t = -1;
        logic prev;
        bit lead, rising, gap_here;
        int exp_iv;

        @(negedge clk);
        len_m1 = lm1; lsb_first = lsb; tx_on_fall = txf; rx_on_fall = rxf;
        sclk_idle = idl; suspend_en = susp; gap_len = g; half_div = hd; tx_word = tw;
        miso = slave_seq[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (ss_n !== 1'b0) err_t++;
        prev = idl;
        while (done_t < 0 && t < 20000) begin
            @(negedge clk);
            t++;
            if (poke && t == 5) begin
                start = 1'b1; tx_word = ~tw; len_m1 = lm1 ^ 5'h10; lsb_first = ~lsb;
            end else begin
                start = 1'b0;
            end
            if (sclk !== prev) begin
                lead     = (sclk != idl);
                rising   = sclk;
                gap_here = susp && n == 32 && (k == 8 || k == 16 || k == 24);
                exp_iv   = (lead && gap_here) ? h * (2 * int'(g) + 3) : h;
                if (t - last_t != exp_iv) begin
                    if (gap_here) err_g++;
                    else          err_t++;
                end
                if ((txf ? rising : !rising) && k < 32) cap[k] = mosi;
                if (rxf ? !rising : rising) begin
                    sidx++;
                    if (sidx < n) miso = slave_seq[sidx];
                end
                if (!lead) k++;
                last_t = t;
                prev   = sclk;
            end
            if (done === 1'b1) done_t = t;
            else if (ss_n !== 1'b0) err_t++;
        end
        chk(k == n, "R2 period count", k, n);
        chk(err_t == 0, "R6 half-period timing", err_t, 0);
        chk((cap & len_mask(n)) == exp_tx, lsb ? "R3 R4 lsb-first mosi" : "R3 R4 msb-first mosi",
            cap & len_mask(n), exp_tx);
        chk(rx_word == (sw & len_mask(n)), "R3 R5 rx_word", rx_word, sw & len_mask(n));
        chk(done_t == last_t + 1 && ss_n === 1'b1 && busy === 1'b0, "R8 done timing",
            done_t, last_t + 1);
        if (susp) chk(err_g == 0, "R7 suspend gap", err_g, 0);
        repeat (3) @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0 && ss_n === 1'b1 && sclk === idl,
            poke ? "R9 no restart" : "R1 idle after", {ss_n, busy, done, sclk}, {1'b1, 1'b0, 1'b0, idl});
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(ss_n === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 reset outputs", {ss_n, busy, done}, 3'b100);
        chk(rx_word === 32'd0, "R1 reset rx_word", rx_word, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk === 1'b1, "R1 idle level", sclk, 1);

        // directed corners
        run_xfer(5'd7,  0, 0, 0, 0, 0, 4'd0,  8'd0, 32'h0000_00A5, 32'h0000_003C, 0);
        run_xfer(5'd3,  0, 1, 1, 1, 0, 4'd0,  8'd1, 32'h0000_0081, 32'h0000_00E7, 0); // R2 clamp
        run_xfer(5'd31, 1, 0, 1, 0, 0, 4'd0,  8'd0, 32'hDEAD_BEEF, 32'h1234_5678, 0);
        run_xfer(5'd31, 0, 1, 0, 1, 1, 4'd0,  8'd0, 32'hCAFE_F00D, 32'h8001_7FFE, 0); // R7 short gap
        run_xfer(5'd31, 1, 0, 0, 0, 1, 4'd15, 8'd2, 32'h0F0F_5AA5, 32'hFFFF_0001, 0); // R7 long gap
        run_xfer(5'd15, 0, 0, 1, 1, 1, 4'd9,  8'd0, 32'h0000_9C3B, 32'h0000_4D21, 0); // R7 inactive
        run_xfer(5'd19, 1, 1, 0, 0, 0, 4'd0,  8'd3, 32'h000A_5F01, 32'h0005_3C3C, 1); // R9
        run_xfer(5'd11, 0, 1, 1, 0, 0, 4'd0,  8'd0, 32'h0000_0ABC, 32'h0000_0FFF, 0);

        // constrained random
        for (int i = 0; i < 24; i++) begin
            run_xfer(5'($urandom_range(0, 31)), 1'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom_range(0, 3)),
                     $urandom, $urandom, (i % 6) == 3);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule